// File: doc/BRIEF.md
# Write-Once Watchdog and Bus-Cycle Timeout Monitor

This block protects a system against runaway software and hung bus transfers. A single configuration byte, which can be written only once after a pin reset, enables the watchdog and sets up three things. The first is the action taken on expiry: an interrupt that stays asserted, or a system reset request. The second is the timeout, built from an optional divide-by-512 prescaler and one of four power-of-two lengths. The third is a separate monitor that flags bus cycles that run too long.

Software keeps the watchdog quiet by writing the key 0x55 and then the key 0xAA to the service register. Any other write to that register breaks the pair. A status register tells software whether the last reset came from the pin or from the watchdog. Accesses use a byte-wide write strobe and read strobe with a 2-bit address: configuration at 0, service at 1, status at 2.

Top module: `wdg_guard`

## Requirements
- R1: After a pin reset (rst_n low), the interrupt, reset request and bus-error outputs are low. Configuration reads 0x00 and status reads 0x80.
- R2: The first write to address 0 after reset is stored and read back unchanged. Any later write to address 0 is ignored until the next reset. A first write of 0x00 also locks the register.
- R3: Configuration bit 5 chooses a tick of every clock (0) or of every 2^PRE_LOG2 clocks (1). Bits 4:3 (sel) set a limit of 2^(TMO_BASE+2*sel) ticks. The watchdog expires exactly at that many clocks after the restart edge. The defaults TMO_BASE=9 and PRE_LOG2=9 give, for code {bit5,bits4:3}, the values 000=2^9, 001=2^11, 010=2^13, 011=2^15, 100=2^18, 101=2^20, 110=2^22 and 111=2^24 clocks.
- R4: With configuration bit 7 at 0 the watchdog never raises an interrupt or a reset request.
- R5: A write of 0x55 to address 1 followed by a write of 0xAA to address 1 restarts the count at the 0xAA edge. The configuration write also restarts it.
- R6: A service write that is not the expected next key returns the sequence to waiting for 0x55 and does not restart the count. Both 0x55,0x12,0xAA and 0x55,0x55,0xAA fail to restart it.
- R7: With configuration bit 6 at 0, expiry raises wdt_irq. The interrupt stays high until a valid service pair, falls at the 0xAA edge, and the count then starts again from zero.
- R8: With configuration bit 6 at 1, expiry gives a one-clock sys_rst_req pulse. In that same clock the block returns to its reset state, with configuration 0x00 and writable again, and status reads 0x20.
- R9: Any write to address 2 clears the status register to 0x00.
- R10: Configuration bit 2 enables the bus monitor. Bits 1:0 select a limit of 2^(BM_BASE+3-bsel) clocks; the default BM_BASE=7 gives 00=1024, 01=512, 10=256, 11=128.
- R11: bus_err pulses for one clock when bus_busy has been high for the limit number of consecutive clocks, and does not pulse again during the same cycle. A low clock clears the count, and the monitor stays silent when disabled.
- R12: rd_data is 0x00 while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low pin reset, asynchronous |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address: 0 configuration, 1 service, 2 status |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, zero when rd_en is low |
| bus_busy | input | 1 | High while a bus cycle is in progress |
| wdt_irq | output | 1 | High-priority watchdog interrupt, held until serviced |
| sys_rst_req | output | 1 | One-clock system reset request on expiry |
| bus_err | output | 1 | One-clock pulse when a bus cycle exceeds its limit |

## Verification
The timeout is tried with random prescale and length codes, including the shortest and longest, and with a valid service pair placed at a random point inside the window. This shows whether the restart lands on the 0xAA edge rather than on the configuration write. Broken key orders (a wrong byte, or a repeated 0x55) must leave expiry at its original clock. Holding the interrupt for random lengths before servicing separates a latched interrupt from a pulsed one. The bus monitor is driven with a cycle that ends one clock short of each limit and then with one that runs past it, which separates an off-by-one limit, a missing clear and a repeated pulse.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam logic [1:0] ADDR_CFG  = 2'd0;
    localparam logic [1:0] ADDR_SVC  = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    localparam logic [7:0] STAT_PIN = 8'h80;
    localparam logic [7:0] STAT_WDT = 8'h20;

    // configuration byte, MSB first
    typedef struct packed {
        logic       enable;     // bit 7
        logic       act_reset;  // bit 6
        logic       prescale;   // bit 5
        logic [1:0] tmo_sel;    // bits 4:3
        logic       bm_enable;  // bit 2
        logic [1:0] bm_sel;     // bits 1:0
    } cfg_t;

endpackage

// File: rtl/wdg_keyseq.sv
module wdg_keyseq
    import wdg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       wr_svc,
    input  logic [7:0] data,
    output logic       svc
);

    logic armed_d, armed_q;

    always_comb begin
        armed_d = armed_q;
        svc     = wr_svc && armed_q && (data == KEY_SECOND);
        if (clr) begin
            armed_d = 1'b0;
        end else if (wr_svc) begin
            // only 0x55 from idle arms; anything else drops back to idle
            armed_d = !armed_q && (data == KEY_FIRST);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= armed_d;
    end

endmodule

// File: rtl/wdg_timer.sv
module wdg_timer #(
    parameter int TMO_BASE = 9,
    parameter int PRE_LOG2 = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       enable,
    input  logic       prescale,
    input  logic [1:0] sel,
    input  logic       restart,
    input  logic       hold,
    output logic       expire
);

    localparam int CNT_W = TMO_BASE + 7;
    localparam int PRE_W = PRE_LOG2;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t       st_d, st_q;
    logic       tick;
    logic [CNT_W-1:0] last;

    always_comb begin
        last   = (CNT_W'(1) << (TMO_BASE + 2 * int'(sel))) - CNT_W'(1);
        tick   = !prescale || (st_q.pre == '1);
        expire = enable && !hold && !restart && tick && (st_q.cnt == last);
        st_d   = st_q;
        if (clr || restart || !enable) begin
            st_d = '0;
        end else if (!hold) begin
            if (prescale) st_d.pre = st_q.pre + PRE_W'(1);
            if (tick)     st_d.cnt = expire ? '0 : st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/wdg_busmon.sv
module wdg_busmon #(
    parameter int BM_BASE = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       enable,
    input  logic [1:0] sel,
    input  logic       busy,
    output logic       bus_err
);

    localparam int BW = BM_BASE + 4;

    typedef struct packed {
        logic [BW-1:0] cnt;
        logic          err;
    } bm_t;

    bm_t           st_d, st_q;
    logic [BW-1:0] limit;

    always_comb begin
        limit    = BW'(1) << (BM_BASE + 3 - int'(sel));
        st_d     = st_q;
        st_d.err = 1'b0;
        if (clr || !enable || !busy) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != limit) begin
            st_d.cnt = st_q.cnt + BW'(1);
            st_d.err = (st_q.cnt == limit - BW'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_err = st_q.err;

endmodule

// File: rtl/wdg_guard.sv
module wdg_guard
    import wdg_pkg::*;
#(
    parameter int TMO_BASE = 9,
    parameter int PRE_LOG2 = 9,
    parameter int BM_BASE  = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [1:0] addr,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       bus_busy,
    output logic       wdt_irq,
    output logic       sys_rst_req,
    output logic       bus_err
);

    typedef struct packed {
        cfg_t       cfg;
        logic       cfg_done;
        logic       irq;
        logic       rst_req;
        logic [7:0] status;
    } top_t;

    top_t st_d, st_q;

    logic cfg_wr, wr_svc, wr_stat, svc, expire, wd_reset, restart;
    logic       cfg_lock;
    logic [7:0] cfg_val;
    logic [7:0] stat_val;

    assign cfg_wr   = wr_en && (addr == ADDR_CFG) && !st_q.cfg_done;
    assign wr_svc   = wr_en && (addr == ADDR_SVC);
    assign wr_stat  = wr_en && (addr == ADDR_STAT);
    assign restart  = svc || cfg_wr;
    assign wd_reset = expire && st_q.cfg.act_reset;

    wdg_keyseq u_keys (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (wd_reset),
        .wr_svc (wr_svc),
        .data   (wr_data),
        .svc    (svc)
    );

    wdg_timer #(.TMO_BASE(TMO_BASE), .PRE_LOG2(PRE_LOG2)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (wd_reset),
        .enable   (st_q.cfg.enable),
        .prescale (st_q.cfg.prescale),
        .sel      (st_q.cfg.tmo_sel),
        .restart  (restart),
        .hold     (st_q.irq),
        .expire   (expire)
    );

    wdg_busmon #(.BM_BASE(BM_BASE)) u_bmon (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (wd_reset),
        .enable  (st_q.cfg.bm_enable),
        .sel     (st_q.cfg.bm_sel),
        .busy    (bus_busy),
        .bus_err (bus_err)
    );

    always_comb begin
        st_d         = st_q;
        st_d.rst_req = 1'b0;
        if (wr_stat) st_d.status = 8'h00;
        if (cfg_wr) begin
            st_d.cfg      = cfg_t'(wr_data);
            st_d.cfg_done = 1'b1;
        end
        if (svc)                               st_d.irq = 1'b0;
        else if (expire && !st_q.cfg.act_reset) st_d.irq = 1'b1;
        if (wd_reset) begin
            st_d.cfg      = '0;
            st_d.cfg_done = 1'b0;
            st_d.irq      = 1'b0;
            st_d.rst_req  = 1'b1;
            st_d.status   = STAT_WDT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.status <= STAT_PIN;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data = 8'h00;
        if (rd_en) begin
            case (addr)
                ADDR_CFG:  rd_data = st_q.cfg;
                ADDR_STAT: rd_data = st_q.status;
                default:   rd_data = 8'h00;
            endcase
        end
    end

    assign wdt_irq     = st_q.irq;
    assign sys_rst_req = st_q.rst_req;
    assign cfg_lock    = st_q.cfg_done;
    assign cfg_val     = st_q.cfg;
    assign stat_val    = st_q.status;

endmodule

// File: rtl/wdg_guard_chk.sv
module wdg_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_lock,
    input logic [7:0] cfg_val,
    input logic [7:0] stat_val,
    input logic       svc,
    input logic       wdt_irq,
    input logic       sys_rst_req,
    input logic       bus_err,
    input logic       bus_busy
);

    // R2: a locked configuration only changes through a watchdog reset
    a_r2_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_lock |=> (sys_rst_req || $stable(cfg_val)));

    // R4: no interrupt while the watchdog is disabled
    a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_val[7] |-> !wdt_irq);

    // R7: the interrupt holds until serviced
    a_r7_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_irq && !svc) |=> wdt_irq);

    // R7: a valid service pair drops the interrupt
    a_r7_irq_release: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_irq && svc) |=> !wdt_irq);

    // R8: the reset request lasts one clock
    a_r8_rst_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |=> !sys_rst_req);

    // R8: a reset request comes with watchdog status and an unlocked configuration
    a_r8_rst_status: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> (stat_val == 8'h20 && !cfg_lock));

    // R11: a bus error lasts one clock
    a_r11_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> !bus_err);

    // R11: a bus error follows a clock with the bus busy
    a_r11_err_busy: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_busy));

endmodule

bind wdg_guard wdg_guard_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_lock    (cfg_lock),
    .cfg_val     (cfg_val),
    .stat_val    (stat_val),
    .svc         (svc),
    .wdt_irq     (wdt_irq),
    .sys_rst_req (sys_rst_req),
    .bus_err     (bus_err),
    .bus_busy    (bus_busy)
);

// File: tb/wdg_guard_tb.sv
module wdg_guard_tb;

    localparam int TB_TMO = 3;
    localparam int TB_PRE = 2;
    localparam int TB_BM  = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       bus_busy = 1'b0;
    logic       wdt_irq, sys_rst_req, bus_err;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    wdg_guard #(.TMO_BASE(TB_TMO), .PRE_LOG2(TB_PRE), .BM_BASE(TB_BM)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .bus_busy(bus_busy),
        .wdt_irq(wdt_irq), .sys_rst_req(sys_rst_req), .bus_err(bus_err)
    );

    function automatic int wdt_clocks(bit pre, int sel);
        return (1 << (TB_TMO + 2 * sel)) * (pre ? (1 << TB_PRE) : 1);
    endfunction

    function automatic int bm_clocks(int bsel);
        return 1 << (TB_BM + 3 - bsel);
    endfunction

    function automatic logic [7:0] cfg_byte(bit en, bit rst, bit pre, int sel, bit bm, int bsel);
        return {en, rst, pre, sel[1:0], bm, bsel[1:0]};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; bus_busy = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic wr_reg(logic [1:0] a, logic [7:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_reg(logic [1:0] a, output logic [7:0] d);
        rd_en = 1'b1; addr = a;
        #1;
        d = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog timer expired before the bench completed");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd7781));

        // R1: pin reset state
        do_reset();
        check("R1 irq", wdt_irq, 0);
        check("R1 rst_req", sys_rst_req, 0);
        check("R1 bus_err", bus_err, 0);
        rd_reg(2'd2, d); check("R1 status", d, 8'h80);
        rd_reg(2'd0, d); check("R1 cfg", d, 8'h00);
        // R12: read data gated by rd_en
        addr = 2'd2; #1; check("R12 rd gated", rd_data, 8'h00);
        // R9: status write clears
        wr_reg(2'd2, 8'h5A);
        rd_reg(2'd2, d); check("R9 status cleared", d, 8'h00);

        // R2 / R4: disabled configuration locks and stays quiet
        wr_reg(2'd0, 8'h18);
        rd_reg(2'd0, d); check("R2 first write", d, 8'h18);
        wr_reg(2'd0, 8'hFF);
        rd_reg(2'd0, d); check("R2 second write ignored", d, 8'h18);
        tick(2100);
        check("R4 no irq when disabled", wdt_irq, 0);
        check("R4 no reset when disabled", sys_rst_req, 0);

        // R6: broken key orders do not restart
        for (int v = 0; v < 2; v++) begin
            int len;
            len = wdt_clocks(0, 3);
            do_reset();
            wr_reg(2'd0, cfg_byte(1, 0, 0, 3, 0, 0));
            tick(100);
            wr_reg(2'd1, 8'h55);
            wr_reg(2'd1, (v == 0) ? 8'h12 : 8'h55);
            wr_reg(2'd1, 8'hAA);
            tick(len - 104);
            check("R6 no irq before original limit", wdt_irq, 0);
            tick(1);
            check("R6 irq at original limit", wdt_irq, 1);
        end

        // R3 / R5 / R7: random codes with a service inside the window
        for (int t = 0; t < 12; t++) begin
            bit pre;
            int sel, len, w, h;
            if (t == 0)      begin pre = 0; sel = 0; end
            else if (t == 1) begin pre = 1; sel = 3; end
            else             begin pre = 1'($urandom % 2); sel = int'($urandom % 4); end
            len = wdt_clocks(pre, sel);
            do_reset();
            wr_reg(2'd0, cfg_byte(1, 0, pre, sel, 0, 0));
            w = int'($urandom % (len - 2));
            tick(w);
            wr_reg(2'd1, 8'h55);
            wr_reg(2'd1, 8'hAA);
            tick(len - 1);
            check("R5 no irq before limit after service", wdt_irq, 0);
            tick(1);
            check("R3 irq at limit", wdt_irq, 1);
            h = int'($urandom % 20) + 1;
            tick(h);
            check("R7 irq held", wdt_irq, 1);
            wr_reg(2'd1, 8'h55);
            wr_reg(2'd1, 8'hAA);
            check("R7 irq released by service", wdt_irq, 0);
            tick(len - 1);
            check("R7 restart from zero, before limit", wdt_irq, 0);
            tick(1);
            check("R7 restart from zero, at limit", wdt_irq, 1);
        end

        // R8: reset action
        begin
            int len;
            len = wdt_clocks(0, 1);
            do_reset();
            wr_reg(2'd0, cfg_byte(1, 1, 0, 1, 0, 0));
            tick(len - 1);
            check("R8 no reset before limit", sys_rst_req, 0);
            tick(1);
            check("R8 reset request at limit", sys_rst_req, 1);
            check("R8 no irq in reset mode", wdt_irq, 0);
            rd_reg(2'd2, d); check("R8 status after watchdog reset", d, 8'h20);
            rd_reg(2'd0, d); check("R8 cfg cleared", d, 8'h00);
            tick(1);
            check("R8 reset request one clock", sys_rst_req, 0);
            wr_reg(2'd0, 8'h07);
            rd_reg(2'd0, d); check("R8 cfg writable again", d, 8'h07);
            wr_reg(2'd2, 8'h00);
            rd_reg(2'd2, d); check("R9 status cleared after watchdog reset", d, 8'h00);
        end

        // R10 / R11: bus monitor limits, clear and single pulse
        for (int bs = 0; bs < 4; bs++) begin
            int lim;
            lim = bm_clocks(bs);
            do_reset();
            wr_reg(2'd0, cfg_byte(0, 0, 0, 0, 1, bs));
            bus_busy = 1'b1;
            tick(lim - 1);
            check("R11 no error one short", bus_err, 0);
            bus_busy = 1'b0;
            tick(1);
            check("R11 cycle end clears", bus_err, 0);
            bus_busy = 1'b1;
            tick(lim - 1);
            check("R10 no error before limit", bus_err, 0);
            tick(1);
            check("R10 error at limit", bus_err, 1);
            tick(1);
            check("R11 error one clock", bus_err, 0);
            begin
                int seen;
                seen = 0;
                for (int k = 0; k < lim + 2; k++) begin
                    tick(1);
                    if (bus_err) seen++;
                end
                check("R11 no repeat in same cycle", seen, 0);
            end
            bus_busy = 1'b0;
        end

        // R11: disabled monitor stays silent
        begin
            int seen;
            do_reset();
            wr_reg(2'd0, 8'h03);
            bus_busy = 1'b1;
            seen = 0;
            for (int k = 0; k < 80; k++) begin
                tick(1);
                if (bus_err) seen++;
            end
            bus_busy = 1'b0;
            check("R11 disabled monitor silent", seen, 0);
        end

        finish_run();
    end

endmodule